// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a byte-wide window onto a bank of internal control registers through a single control offset. The host writes a register pointer to the control offset and then either writes a data byte to it or reads the addressed register back from it. A small state machine remembers whether the next control write is taken as a pointer or as data. The register bank also has a reset bit in register 0. While that bit is set, the interface is held in a reset state and ignores control writes that would leave the bit set.

Three further offsets give direct reads of three input ports. These reads bypass the pointer logic. Because the pointer and the data share one offset, a host that has lost track of the interface can recover with a fixed six-access sequence on the control offset: read, write 0x00, read, write 0x00, write 0x01, write 0x00. The sequence ends in the pointer-expected state with register 0 cleared, whatever state the interface was in beforehand.

Read data leaves the block as a one-beat response: `host_rvalid` is high for exactly one cycle, and `host_rdata` is valid in that cycle. There is no back-pressure on the response path. The host must take each response in the cycle it appears.

Top module: `ind_reg_port`

## Requirements
- R1: After `rst_n` is released, `in_reset` is 1. A control read (offset 3) returns 0x01, which is register 0 with its reset bit (bit 0) set, and every other register reads as 0x00.
- R2: While held in reset, a control write with bit 0 = 1 is ignored. A control write with bit 0 = 0 stores the byte into register 0, leaves the reset state and enters the pointer-expected state.
- R3: In the pointer-expected state, a control write loads the pointer from the low log2(NREG) bits of the byte and moves to the data-expected state. Pointer bits above that width are discarded, so the pointer wraps.
- R4: In the data-expected state, a control write stores the byte into the register at the pointer and returns to the pointer-expected state.
- R5: A control read returns the register at the pointer. In the pointer-expected state the state is left unchanged. In the data-expected state the state returns to pointer-expected. While held in reset, a control read returns register 0 and the state is left unchanged.
- R6: A data write of a byte with bit 0 = 1 to register 0 enters the reset state. It stores the byte in register 0 and clears every other register to 0x00.
- R7: From any state, the six-access control sequence (read, write 0x00, read, write 0x00, write 0x01, write 0x00) leaves `in_reset` = 0 and register 0 = 0x00. The next control write is then taken as a pointer.
- R8: Reads at offsets 0, 1 and 2 return `port_c_in`, `port_b_in` and `port_a_in` respectively. Writes to these offsets are ignored. No access to offsets 0 to 2 changes the state, the pointer or the registers.
- R9: Every read produces exactly one response, one cycle later, with `host_rvalid` = 1 and `host_rdata` registered. An access with both `host_wr` and `host_rd` high is performed as a write only and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Offset: 0/1/2 are direct ports C/B/A, 3 is the control offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read response byte |
| host_rvalid | output | 1 | Read response valid, one cycle, no back-pressure |
| port_a_in | input | 8 | Direct input port A |
| port_b_in | input | 8 | Direct input port B |
| port_c_in | input | 8 | Direct input port C |
| in_reset | output | 1 | High while the interface is held in reset |

## Verification
The hardest situation to reach from the ports is an interface whose state is unknown to the host. Examples are a half-finished pointer/data pair, or an accidental entry into reset caused by a stray write of an odd byte to register 0. To get there, the stimulus runs bursts of random control reads and writes with random values, so every trial starts the recovery sequence from a different one of the three states. A reference model in the bench tracks the state so that each read can be checked. After each burst the six-access sequence is issued, and then fresh writes and reads prove that the pointer and the data phases line up again.

// File: rtl/ind_port_pkg.sv
package ind_port_pkg;
  typedef enum logic [1:0] {
    ST_PTR  = 2'd0,
    ST_DATA = 2'd1,
    ST_HOLD = 2'd2
  } acc_state_e;

  localparam logic [1:0] OFS_PORT_C = 2'd0;
  localparam logic [1:0] OFS_PORT_B = 2'd1;
  localparam logic [1:0] OFS_PORT_A = 2'd2;
  localparam logic [1:0] OFS_CTRL   = 2'd3;

  localparam logic [7:0] REG0_POR = 8'h01;
endpackage

// File: rtl/acc_fsm.sv
module acc_fsm
  import ind_port_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic [7:0]       wdata,
  output acc_state_e       state,
  output logic [PTR_W-1:0] ptr,
  output logic             bank_we,
  output logic             bank_clr,
  output logic [PTR_W-1:0] bank_addr
);
  acc_state_e       nxt_state;
  logic [PTR_W-1:0] nxt_ptr;

  assign bank_addr = (state == ST_HOLD) ? '0 : ptr;

  always_comb begin
    nxt_state = state;
    nxt_ptr   = ptr;
    bank_we   = 1'b0;
    bank_clr  = 1'b0;
    if (ctl_wr) begin
      unique case (state)
        ST_PTR: begin
          nxt_ptr   = wdata[PTR_W-1:0];
          nxt_state = ST_DATA;
        end
        ST_DATA: begin
          bank_we = 1'b1;
          if (ptr == '0 && wdata[0]) begin
            bank_clr  = 1'b1;
            nxt_state = ST_HOLD;
          end else begin
            nxt_state = ST_PTR;
          end
        end
        ST_HOLD: begin
          if (!wdata[0]) begin
            bank_we   = 1'b1;
            nxt_state = ST_PTR;
          end
        end
        default: nxt_state = ST_HOLD;
      endcase
    end else if (ctl_rd && state == ST_DATA) begin
      nxt_state = ST_PTR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      ptr   <= '0;
    end else begin
      state <= nxt_state;
      ptr   <= nxt_ptr;
    end
  end

  p_hold_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && ctl_wr && !wdata[0]) |=> state == ST_PTR);

  p_hold_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && ctl_wr && wdata[0]) |=> state == ST_HOLD);

  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PTR && ctl_wr) |=> (state == ST_DATA && ptr == $past(wdata[PTR_W-1:0])));

  p_rd_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PTR && ctl_rd && !ctl_wr) |=> (state == ST_PTR && $stable(ptr)));

  p_rd_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && ctl_rd && !ctl_wr) |=> state == ST_PTR);

  p_no_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !ctl_rd) |=> ($stable(state) && $stable(ptr)));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import ind_port_pkg::*;
#(
  parameter int NREG  = 64,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             clr,
  input  logic [PTR_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_data
);
  logic [7:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= (i == 0) ? REG0_POR : 8'h00;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we && addr == PTR_W'(i)) mem[i] <= wdata;
        else if (clr)                mem[i] <= 8'h00;
      end
    end
  end

  assign rd_data = mem[addr];

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(addr)] == $past(wdata));

  p_clear_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && addr != PTR_W'(NREG-1)) |=> mem[NREG-1] == 8'h00);
endmodule

// File: rtl/rsp_path.sv
module rsp_path
  import ind_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [7:0] port_a,
  input  logic [7:0] port_b,
  input  logic [7:0] port_c,
  input  logic [7:0] bank_data,
  output logic       rvalid,
  output logic [7:0] rdata
);
  logic [7:0] sel;

  always_comb begin
    unique case (addr)
      OFS_PORT_C: sel = port_c;
      OFS_PORT_B: sel = port_b;
      OFS_PORT_A: sel = port_a;
      default:    sel = bank_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= 8'h00;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel;
    end
  end

  p_one_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
endmodule

// File: rtl/ind_reg_port.sv
module ind_reg_port
  import ind_port_pkg::*;
#(
  parameter int NREG = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  input  logic [7:0] port_a_in,
  input  logic [7:0] port_b_in,
  input  logic [7:0] port_c_in,
  output logic       in_reset
);
  localparam int PTR_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic             rd_ok, ctl_wr, ctl_rd;
  acc_state_e       state;
  logic [PTR_W-1:0] ptr, bank_addr;
  logic             bank_we, bank_clr;
  logic [7:0]       bank_data;

  assign rd_ok  = host_rd && !host_wr;
  assign ctl_wr = host_wr && host_addr == OFS_CTRL;
  assign ctl_rd = rd_ok && host_addr == OFS_CTRL;

  acc_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .wdata(host_wdata), .state(state), .ptr(ptr), .bank_we(bank_we),
    .bank_clr(bank_clr), .bank_addr(bank_addr)
  );

  reg_bank #(.NREG(NREG), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .clr(bank_clr),
    .addr(bank_addr), .wdata(host_wdata), .rd_data(bank_data)
  );

  rsp_path u_rsp (
    .clk(clk), .rst_n(rst_n), .rd(rd_ok), .addr(host_addr),
    .port_a(port_a_in), .port_b(port_b_in), .port_c(port_c_in),
    .bank_data(bank_data), .rvalid(host_rvalid), .rdata(host_rdata)
  );

  assign in_reset = (state == ST_HOLD);

  p_both_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd) |=> !host_rvalid);

  p_enter_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && state == ST_DATA && ptr == '0 && host_wdata[0]) |=> in_reset);
endmodule

// File: tb/ind_reg_port_tb.sv
module ind_reg_port_tb;
  localparam int NREG = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic [7:0] port_a_in = 8'hA5, port_b_in = 8'h3C, port_c_in = 8'h5E;
  logic       in_reset;

  always #2 clk = ~clk;

  ind_reg_port #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .port_a_in(port_a_in), .port_b_in(port_b_in),
    .port_c_in(port_c_in), .in_reset(in_reset)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  // reference model: 0 pointer-expected, 1 data-expected, 2 held in reset
  int         m_st;
  int         m_ptr;
  logic [7:0] m_regs [NREG];

  task automatic m_init();
    m_st = 2; m_ptr = 0;
    for (int i = 0; i < NREG; i++) m_regs[i] = (i == 0) ? 8'h01 : 8'h00;
  endtask

  task automatic m_ctl_wr(input logic [7:0] d);
    if (m_st == 0) begin
      m_ptr = d & (NREG - 1); m_st = 1;
    end else if (m_st == 1) begin
      m_regs[m_ptr] = d;
      if (m_ptr == 0 && d[0]) begin
        for (int i = 1; i < NREG; i++) m_regs[i] = 8'h00;
        m_st = 2;
      end else m_st = 0;
    end else if (!d[0]) begin
      m_regs[0] = d; m_st = 0;
    end
  endtask

  task automatic bus(input logic [1:0] a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    if (a == 2'd3) m_ctl_wr(d);
    bus(a, 1'b1, 1'b0, d);
  endtask

  task automatic do_rd(input logic [1:0] a, input string tag);
    logic [7:0] e;
    case (a)
      2'd0: e = port_c_in;
      2'd1: e = port_b_in;
      2'd2: e = port_a_in;
      default: begin
        e = (m_st == 2) ? m_regs[0] : m_regs[m_ptr];
        if (m_st == 1) m_st = 0;
      end
    endcase
    exp_q.push_back(e); tag_q.push_back(tag);
    bus(a, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic chk_reset_pin(input string tag);
    checks++;
    if (in_reset !== (m_st == 2)) begin
      errors++;
      $display("FAIL %s in_reset actual=%0b expected=%0b", tag, in_reset, (m_st == 2));
    end
  endtask

  task automatic recover();
    do_rd(2'd3, "R7");
    do_wr(2'd3, 8'h00);
    do_rd(2'd3, "R7");
    do_wr(2'd3, 8'h00);
    do_wr(2'd3, 8'h01);
    do_wr(2'd3, 8'h00);
  endtask

  // monitor: compares each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected response actual=%02h expected=none", host_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s rdata actual=%02h expected=%02h", t, host_rdata, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_pin("R1");
    do_rd(2'd3, "R1");
    // R2: write with bit 0 set is ignored while in reset
    do_wr(2'd3, 8'h07);
    chk_reset_pin("R2");
    do_rd(2'd3, "R2");
    do_wr(2'd3, 8'h40);
    chk_reset_pin("R2");
    do_rd(2'd3, "R2");              // pointer-expected: reads reg 0 = 0x40
    // R3/R4: write a few registers, including wrapped pointer
    do_wr(2'd3, 8'h05); do_wr(2'd3, 8'h9A);
    do_wr(2'd3, 8'hC7); do_wr(2'd3, 8'h3E);   // pointer wraps to 7
    do_wr(2'd3, 8'h3F); do_wr(2'd3, 8'h81);
    do_wr(2'd3, 8'h05); do_rd(2'd3, "R4");
    do_rd(2'd3, "R5");              // stays pointer-expected, ptr 5
    do_wr(2'd3, 8'h07); do_rd(2'd3, "R3");
    do_wr(2'd3, 8'h3F); do_rd(2'd3, "R4");
    // R1 follow-up: untouched register reads zero
    do_wr(2'd3, 8'h10); do_rd(2'd3, "R1");
    // R8: direct ports and ignored writes
    do_rd(2'd0, "R8"); do_rd(2'd1, "R8"); do_rd(2'd2, "R8");
    port_a_in = 8'h11; port_c_in = 8'hEE;
    do_rd(2'd2, "R8"); do_rd(2'd0, "R8");
    do_wr(2'd3, 8'h05);             // now data-expected
    do_wr(2'd1, 8'hFF); do_rd(2'd2, "R8");
    do_wr(2'd3, 8'h66);             // data phase still pending
    do_wr(2'd3, 8'h05); do_rd(2'd3, "R8");
    // R9: write+read at once behaves as write, no response
    do_wr(2'd3, 8'h02);
    m_ctl_wr(8'h77);
    bus(2'd3, 1'b1, 1'b1, 8'h77);
    do_wr(2'd3, 8'h02); do_rd(2'd3, "R9");
    // R6: reset bit via data write clears the bank
    do_wr(2'd3, 8'h00); do_wr(2'd3, 8'h03);
    chk_reset_pin("R6");
    do_rd(2'd3, "R6");
    do_wr(2'd3, 8'h00);
    do_wr(2'd3, 8'h3F); do_rd(2'd3, "R6");
    do_wr(2'd3, 8'h05); do_rd(2'd3, "R6");
    // R7: random partial traffic then the recovery sequence
    for (int t = 0; t < 40; t++) begin
      int n;
      n = $urandom_range(0, 6);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 2) == 0) do_rd(2'd3, "R5");
        else do_wr(2'd3, 8'($urandom_range(0, 255)));
      end
      recover();
      chk_reset_pin("R7");
      checks++;
      if (m_st != 0 || m_regs[0] != 8'h00) begin
        errors++;
        $display("FAIL R7 model state actual=%0d expected=0", m_st);
      end
      begin
        logic [7:0] p, v;
        p = 8'($urandom_range(1, NREG - 1));
        v = 8'($urandom_range(0, 255));
        do_wr(2'd3, p); do_wr(2'd3, v);
        do_wr(2'd3, p); do_rd(2'd3, "R7");
      end
    end
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule